// File: doc/BRIEF.md
# Receive Signaling Reinsertion Selector

This block sits on the receive serial PCM path, one bit per clock. For each bit it decides whether to pass the incoming data through unchanged or to overwrite it with buffered robbed-bit signaling. Signaling is carried in the least significant bit of every channel in certain frames of a multiframe. A position counter outside the block supplies the channel index and the bit index. The buffered signaling bits (A, B, C, D) for the current channel arrive as a 4-bit vector. A multiframe sync pulse marks where frame 1 begins, so that the reinserted bits line up with that boundary.

Reinsertion is switched on by a global enable. With per-channel control on, a block line that is high for a channel's time slot keeps that channel untouched. An all-ones option writes 1 into the signaling positions in place of the buffered bits. The same block line gates this option whenever per-channel control is on.

A two-state machine tracks alignment. `ST_IDLE` is the reset state and passes all data through. It moves to `ST_RUN` on a sync pulse that arrives while the enable is high (transition SYNC_LOCK). `ST_RUN` returns to `ST_IDLE` when the enable drops (transition DISABLE_DROP). The frame counter runs in both states. A sync pulse forces it to frame 1, and it steps on after the last bit of the last channel.

Top module: `rsr_reinsert_sel`

## Requirements
- R1: While `reins_en` is low, `ser_out` equals `ser_in` at every position.
- R2: At every position with `bit_idx` other than 7 (the channel LSB, because bits arrive MSB first at index 0), `ser_out` equals `ser_in` in the same cycle.
- R3: After reset, and after any cycle with `reins_en` low, no bit is replaced until a `mf_sync` pulse arrives while `reins_en` is high.
- R4: `mf_sync` marks channel 0, bit 0 of frame 1. The frame number steps after channel 23, bit 7. It wraps to 1 after frame 24 in extended mode and after frame 12 in short mode.
- R5: With `esf_mode` = 1, the LSB of each channel in frames 6, 12, 18 and 24 is replaced by `sig_bits[0]`, `[1]`, `[2]` and `[3]` respectively.
- R6: With `esf_mode` = 0, only frames 6 and 12 carry signaling, using `sig_bits[0]` and `sig_bits[1]`.
- R7: With `pcc_en` = 0, every channel is reinserted whatever the level of `blk_in`.
- R8: With `pcc_en` = 1, a channel whose block indication is high passes its signaling positions through unchanged.
- R9: `blk_in` is sampled at bit 0 of each slot and that value governs the whole slot, even if `blk_in` changes later in the slot.
- R10: With `ones_en` = 1, every replaced position carries 1 instead of the buffered bit.
- R11: With `pcc_en` = 1, the all-ones replacement is also suppressed in blocked channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_in | input | 1 | Incoming serial PCM bit |
| chan_idx | input | 5 | Current channel, 0 to 23 |
| bit_idx | input | 3 | Current bit in the channel, 0 = MSB |
| mf_sync | input | 1 | Multiframe start pulse (channel 0, bit 0, frame 1) |
| sig_bits | input | 4 | Buffered signaling A/B/C/D for the current channel |
| blk_in | input | 1 | Per-channel block indication |
| reins_en | input | 1 | Global reinsertion enable |
| pcc_en | input | 1 | Per-channel control enable |
| ones_en | input | 1 | Force signaling positions to 1 |
| esf_mode | input | 1 | 1 = 24-frame multiframe, 0 = 12-frame multiframe |
| ser_out | output | 1 | Outgoing serial PCM bit |

## Verification
The bench drives random PCM data and compares every bit against its own frame and alignment model. Each blocked slot has its block line inverted from bit 3 onwards. A design that sampled the line live would then block the wrong channels. The bench moves the sync pulse to a new frame offset and runs short-mode traffic across two multiframes. A counter that ignored the pulse, or wrapped at the wrong length, would put signaling in the wrong frames or miss frames 18 and 24. It also drops and restores the enable without a new pulse. A design that kept its lock across that gap would reinsert before realignment.

// File: rtl/rsr_pkg.sv
`timescale 1ns/1ps
package rsr_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } rsr_state_e;

    // Returns {hit, index}: hit when the frame carries robbed-bit signaling.
    function automatic logic [2:0] sig_lookup(input int frame, input logic ext_mode,
                                              input int spacing);
        int slot;
        int max_slot;
        logic hit;
        slot     = (spacing > 0) ? frame / spacing : 0;
        max_slot = ext_mode ? 4 : 2;
        hit      = (frame > 0) && (spacing > 0) && (frame % spacing == 0) && (slot <= max_slot);
        return {hit, hit ? 2'(slot - 1) : 2'd0};
    endfunction

endpackage

// File: rtl/rsr_frame_tracker.sv
`timescale 1ns/1ps
module rsr_frame_tracker
    import rsr_pkg::*;
#(
    parameter int NUM_CH      = 24,
    parameter int BITS_PER_CH = 8,
    parameter int MF_EXT      = 24,
    parameter int MF_SHORT    = 12,
    parameter int CH_W        = 5,
    parameter int BIT_W       = 3,
    parameter int FR_W        = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reins_en,
    input  logic             mf_sync,
    input  logic             esf_mode,
    input  logic [CH_W-1:0]  chan_idx,
    input  logic [BIT_W-1:0] bit_idx,
    output logic             run,
    output logic [FR_W-1:0]  cur_frame
);
    localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(NUM_CH - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BITS_PER_CH - 1);
    localparam logic [FR_W-1:0]  FR_ONE   = FR_W'(1);

    rsr_state_e state_q, state_d;
    logic [FR_W-1:0] frame_q;
    logic [FR_W-1:0] mf_len;
    logic            frame_end;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (reins_en && mf_sync) state_d = ST_RUN;   // SYNC_LOCK
            ST_RUN:  if (!reins_en)           state_d = ST_IDLE;  // DISABLE_DROP
            default:                          state_d = ST_IDLE;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        run = 1'b0;
        unique case (state_q)
            ST_IDLE: run = 1'b0;
            ST_RUN:  run = 1'b1;
            default: run = 1'b0;
        endcase
    end

    // Frame position within the multiframe
    assign mf_len    = esf_mode ? FR_W'(MF_EXT) : FR_W'(MF_SHORT);
    assign cur_frame = mf_sync ? FR_ONE : frame_q;
    assign frame_end = (chan_idx == LAST_CH) && (bit_idx == LAST_BIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            frame_q <= FR_ONE;
        else if (frame_end)
            frame_q <= (cur_frame >= mf_len) ? FR_ONE : cur_frame + FR_ONE;
        else if (mf_sync)
            frame_q <= FR_ONE;
    end

endmodule

// File: rtl/rsr_slot_gate.sv
`timescale 1ns/1ps
module rsr_slot_gate #(
    parameter int BIT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BIT_W-1:0] bit_idx,
    input  logic             blk_in,
    output logic             blk_eff
);
    logic blk_q;
    logic slot_start;

    assign slot_start = (bit_idx == '0);
    assign blk_eff    = slot_start ? blk_in : blk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          blk_q <= 1'b0;
        else if (slot_start) blk_q <= blk_in;
    end

endmodule

// File: rtl/rsr_reinsert_sel.sv
`timescale 1ns/1ps
module rsr_reinsert_sel
    import rsr_pkg::*;
#(
    parameter int NUM_CH      = 24,
    parameter int BITS_PER_CH = 8,
    parameter int SIG_SPACING = 6,
    parameter int SIG_BITS    = 4,
    parameter int CH_W        = $clog2(NUM_CH),
    parameter int BIT_W       = $clog2(BITS_PER_CH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_in,
    input  logic [CH_W-1:0]     chan_idx,
    input  logic [BIT_W-1:0]    bit_idx,
    input  logic                mf_sync,
    input  logic [SIG_BITS-1:0] sig_bits,
    input  logic                blk_in,
    input  logic                reins_en,
    input  logic                pcc_en,
    input  logic                ones_en,
    input  logic                esf_mode,
    output logic                ser_out
);
    localparam int MF_EXT   = SIG_SPACING * SIG_BITS;
    localparam int MF_SHORT = SIG_SPACING * 2;
    localparam int FR_W     = $clog2(MF_EXT + 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BITS_PER_CH - 1);

    logic            run;
    logic [FR_W-1:0] cur_frame;
    logic            blk_eff;
    logic [2:0]      lookup;
    logic            robbed_pos;
    logic            replace;
    logic            sig_val;

    rsr_frame_tracker #(
        .NUM_CH(NUM_CH), .BITS_PER_CH(BITS_PER_CH),
        .MF_EXT(MF_EXT), .MF_SHORT(MF_SHORT),
        .CH_W(CH_W), .BIT_W(BIT_W), .FR_W(FR_W)
    ) u_track (
        .clk(clk), .rst_n(rst_n), .reins_en(reins_en), .mf_sync(mf_sync),
        .esf_mode(esf_mode), .chan_idx(chan_idx), .bit_idx(bit_idx),
        .run(run), .cur_frame(cur_frame)
    );

    rsr_slot_gate #(.BIT_W(BIT_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .bit_idx(bit_idx), .blk_in(blk_in), .blk_eff(blk_eff)
    );

    always_comb begin
        lookup     = sig_lookup(int'(cur_frame), esf_mode, SIG_SPACING);
        robbed_pos = (bit_idx == LAST_BIT) && lookup[2];
        replace    = run && reins_en && robbed_pos && !(pcc_en && blk_eff);
        sig_val    = ones_en ? 1'b1 : sig_bits[lookup[1:0]];
        ser_out    = replace ? sig_val : ser_in;
    end

endmodule

// File: rtl/rsr_sel_checker.sv
`timescale 1ns/1ps
module rsr_sel_checker #(
    parameter int SIG_BITS    = 4,
    parameter int CH_W        = 5,
    parameter int BIT_W       = 3,
    parameter int BITS_PER_CH = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ser_in,
    input logic [CH_W-1:0]     chan_idx,
    input logic [BIT_W-1:0]    bit_idx,
    input logic                mf_sync,
    input logic [SIG_BITS-1:0] sig_bits,
    input logic                blk_in,
    input logic                reins_en,
    input logic                pcc_en,
    input logic                ones_en,
    input logic                esf_mode,
    input logic                ser_out
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BITS_PER_CH - 1);

    logic locked_q;
    logic slot_blk_q;
    logic blk_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   locked_q <= 1'b0;
        else if (!reins_en)           locked_q <= 1'b0;
        else if (mf_sync)             locked_q <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              slot_blk_q <= 1'b0;
        else if (bit_idx == '0)  slot_blk_q <= blk_in;
    end

    assign blk_now = (bit_idx == '0) ? blk_in : slot_blk_q;

    a_r1_disabled_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        !reins_en |-> (ser_out == ser_in));

    a_r2_data_bits_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_idx != LAST_BIT) |-> (ser_out == ser_in));

    a_r3_unlocked_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        !locked_q |-> (ser_out == ser_in));

    a_r8_blocked_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (pcc_en && blk_now) |-> (ser_out == ser_in));

    a_r10_ones_only_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ones_en && (ser_out != ser_in)) |-> ser_out);

endmodule

bind rsr_reinsert_sel rsr_sel_checker #(
    .SIG_BITS(SIG_BITS), .CH_W(CH_W), .BIT_W(BIT_W), .BITS_PER_CH(BITS_PER_CH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .chan_idx(chan_idx), .bit_idx(bit_idx),
    .mf_sync(mf_sync), .sig_bits(sig_bits), .blk_in(blk_in), .reins_en(reins_en),
    .pcc_en(pcc_en), .ones_en(ones_en), .esf_mode(esf_mode), .ser_out(ser_out)
);

// File: tb/rsr_reinsert_sel_tb.sv
`timescale 1ns/1ps
module rsr_reinsert_sel_tb;
    localparam int NCH = 24;
    localparam int NB  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_in = 1'b0;
    logic [4:0] chan_idx = '0;
    logic [2:0] bit_idx = '0;
    logic       mf_sync = 1'b0;
    logic [3:0] sig_bits = 4'b0101;
    logic       blk_in = 1'b0;
    logic       reins_en = 1'b0;
    logic       pcc_en = 1'b0;
    logic       ones_en = 1'b0;
    logic       esf_mode = 1'b1;
    logic       ser_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model state
    bit m_run = 1'b0;
    int m_frame = 1;
    bit m_blk = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    rsr_reinsert_sel u_dut (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .chan_idx(chan_idx), .bit_idx(bit_idx),
        .mf_sync(mf_sync), .sig_bits(sig_bits), .blk_in(blk_in), .reins_en(reins_en),
        .pcc_en(pcc_en), .ones_en(ones_en), .esf_mode(esf_mode), .ser_out(ser_out)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: ser_out=%b expected=%b (ch %0d bit %0d frame %0d)",
                     tag, act, exp, chan_idx, bit_idx, m_frame);
        end
    endtask

    // One bit time: drive after the edge, check at the falling edge, then advance the model.
    task automatic step(input int ch, input int bt, input logic sync, input logic blk,
                        input string tag);
        int cur;
        int len;
        bit hit;
        bit beff;
        logic exp;
        @(posedge clk);
        #1;
        lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        ser_in   = lfsr[0];
        chan_idx = 5'(ch);
        bit_idx  = 3'(bt);
        mf_sync  = sync;
        blk_in   = blk;
        @(negedge clk);
        cur  = sync ? 1 : m_frame;
        len  = esf_mode ? 24 : 12;
        hit  = (bt == NB - 1) && (cur % 6 == 0) && (cur / 6 <= (esf_mode ? 4 : 2));
        beff = (bt == 0) ? blk : m_blk;
        if (m_run && reins_en && hit && !(pcc_en && beff))
            exp = ones_en ? 1'b1 : sig_bits[cur / 6 - 1];
        else
            exp = ser_in;
        check((bt == NB - 1) ? tag : "R2", ser_out, exp);
        // model update for the coming edge
        if (!reins_en)  m_run = 1'b0;
        else if (sync)  m_run = 1'b1;
        if (ch == NCH - 1 && bt == NB - 1) m_frame = (cur >= len) ? 1 : cur + 1;
        else if (sync)                     m_frame = 1;
        if (bt == 0) m_blk = blk;
    endtask

    // Drive whole frames; the block line is inverted from bit 3 on to probe the slot hold (R9).
    task automatic drive_frames(input int nframes, input bit sync_first,
                                input logic [NCH-1:0] mask, input string tag);
        for (int f = 0; f < nframes; f++)
            for (int ch = 0; ch < NCH; ch++)
                for (int bt = 0; bt < NB; bt++)
                    step(ch, bt, sync_first && f == 0 && ch == 0 && bt == 0,
                         (bt < 3) ? mask[ch] : ~mask[ch], tag);
    endtask

    task automatic t_reset;
        // R1: after reset with the enable low the output follows the input
        step(0, 0, 1'b0, 1'b0, "R1");
        step(0, 7, 1'b0, 1'b0, "R1");
    endtask

    task automatic t_disabled;
        reins_en = 1'b0;
        drive_frames(24, 1'b1, 24'h0, "R1");
    endtask

    task automatic t_unsynced;
        reins_en = 1'b1;
        m_frame  = 1;
        drive_frames(12, 1'b0, 24'h0, "R3");
    endtask

    task automatic t_ext_all;
        esf_mode = 1'b1; pcc_en = 1'b0; sig_bits = 4'b0101;
        drive_frames(24, 1'b1, 24'hF0F0F0, "R5");
        sig_bits = 4'b1010;
        drive_frames(24, 1'b0, 24'hFFFFFF, "R7");
    endtask

    task automatic t_short;
        esf_mode = 1'b0; sig_bits = 4'b1101;
        drive_frames(24, 1'b1, 24'h0, "R6");
        esf_mode = 1'b1;
    endtask

    task automatic t_per_channel;
        pcc_en = 1'b1; sig_bits = 4'b0110;
        drive_frames(24, 1'b1, 24'hAAAAAA, "R8");
        drive_frames(12, 1'b0, 24'h0F0F0F, "R9");
        pcc_en = 1'b0;
    endtask

    task automatic t_ones;
        ones_en = 1'b1; sig_bits = 4'b0000;
        drive_frames(24, 1'b1, 24'h333333, "R10");
        pcc_en = 1'b1;
        drive_frames(24, 1'b0, 24'h555555, "R11");
        pcc_en = 1'b0; ones_en = 1'b0;
    endtask

    task automatic t_realign;
        sig_bits = 4'b1001;
        drive_frames(3, 1'b0, 24'h0, "R4");
        drive_frames(24, 1'b1, 24'h0, "R4");
    endtask

    task automatic t_reenable;
        reins_en = 1'b0;
        step(0, 0, 1'b0, 1'b0, "R1");
        reins_en = 1'b1;
        drive_frames(24, 1'b0, 24'h0, "R3");
        drive_frames(12, 1'b1, 24'h0, "R3");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_disabled();
        t_unsynced();
        t_ext_all();
        t_short();
        t_per_channel();
        t_ones();
        t_realign();
        t_reenable();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule